// File: doc/BRIEF.md
# AND-OR Readback Register Bank Pair

Two small banks of 16-bit control and status registers share one internal register bus: a bus address, a write strobe, write data, and read data. Each bank sits at its own base address. It decodes two words there, a status/control word at offset 0 and a data word at offset 1. The bank keeps the writable fields in flip-flops. Read-only bits come straight from a status input.

Read data is produced without an address-driven multiplexer. Each register's value is gated by its own address match, and the gated words are ORed together. Anything not addressed therefore contributes zero. The outputs of the two banks are then merged with a plain bitwise OR. More banks can be added at the same level with no select lines, as long as each one drives zero when it is not addressed.

Top module: `rb_dual_bank`

## Requirements
- R1: A write to the data word (base + 1) with the strobe high takes effect on the next rising clock edge. A later read returns the written value ANDed with 0xFFEB, which is the writable set: bits 15:8, the split field of bits 7:5 plus bit 3, and bits 1:0.
- R2: Bits 4 and 2 of the data word belong to no field. They always read 0, and writes to them are discarded.
- R3: Reading the control word (base + 0) returns the bank's status input on bit 15 in the same cycle, with no register delay. Bits 14:0 of the control word read 0.
- R4: The control word holds no writable state. Bus writes to it leave every later read of that bank unchanged.
- R5: With the write strobe low, the stored data word does not change, whatever address and write data are on the bus.
- R6: Any address other than the four mapped words reads as all zeros.
- R7: A synchronous active-high reset clears every writable field to zero.
- R8: Bank A sits at base 0x3456 and bank B at base 0x5000 by default. Each mapped address returns only its owning bank's value, and a write to one bank never alters the other.
- R9: The read data is the bitwise OR of the two banks' gated outputs, combinationally from the address and status inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| stat_a | input | 1 | Status bit shown in bank A's control word |
| stat_b | input | 1 | Status bit shown in bank B's control word |
| bus_rdata | output | 16 | ORed read data of both banks |

## Verification
The bench probes the addresses just beside each bank: base minus one, base plus two, and the other bank's words. A decoder that is too wide, or off by one, puts data on these unmapped locations, or lets one bank's value show up in the other's OR term. It writes all ones to the data and control words. A mask that leaks shows up as bits 4 or 2 set, or as low bits set in the control word. It also toggles the status bits between a write and a read. A design that latched status, or that stored bus writes into the read-only bit, would then return a stale or corrupted bit 15. Writes with the strobe low and a mid-run reset catch a bank that ignores the strobe or misses its clear.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int DW       = 16;
  localparam int AW       = 16;
  localparam int NREG     = 2;
  localparam int OFS_CTRL = 0;
  localparam int OFS_DATA = 1;

  typedef logic [DW-1:0] word_t;

  // writable bits per register: data word keeps 15:8, 7:5, 3, 1:0
  localparam word_t DATA_RW_MASK = 16'hFFEB;
  // read-only bits per register: control word shows status on bit 15
  localparam word_t CTRL_RO_MASK = 16'h8000;
endpackage

// File: rtl/rb_decode.sv
module rb_decode #(
  parameter int AW   = 16,
  parameter int NREG = 2,
  parameter int BASE = 0
) (
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    localparam logic [AW-1:0] REG_ADDR = AW'(BASE + i);
    assign hit[i] = (addr == REG_ADDR);
  end
endmodule

// File: rtl/rb_or_merge.sv
module rb_or_merge #(
  parameter int DW   = 16,
  parameter int NSRC = 2
) (
  input  logic [NSRC*DW-1:0] src,
  output logic [DW-1:0]      merged
);
  always_comb begin
    merged = '0;
    for (int i = 0; i < NSRC; i++) merged = merged | src[i*DW +: DW];
  end
endmodule

// File: rtl/rb_bank.sv
module rb_bank
  import rb_pkg::*;
#(
  parameter int BASE = 16'h3456
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  input  logic [NREG*DW-1:0] ro_flat,
  output logic [DW-1:0]    rdata
);
  localparam word_t RW_MASK [NREG] = '{16'h0000, DATA_RW_MASK};
  localparam word_t RO_MASK [NREG] = '{CTRL_RO_MASK, 16'h0000};

  logic [NREG-1:0]    hit;
  logic [NREG*DW-1:0] gated;

  rb_decode #(.AW(AW), .NREG(NREG), .BASE(BASE)) u_dec (
    .addr (addr),
    .hit  (hit)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    word_t value;
    if (RW_MASK[i] != '0) begin : g_store
      word_t store_q;
      always_ff @(posedge clk) begin
        if (rst)                store_q <= '0;
        else if (wr && hit[i])  store_q <= wdata & RW_MASK[i];
      end
      assign value = (store_q & RW_MASK[i]) | (ro_flat[i*DW +: DW] & RO_MASK[i]);
    end else begin : g_ro
      assign value = ro_flat[i*DW +: DW] & RO_MASK[i];
    end
    assign gated[i*DW +: DW] = {DW{hit[i]}} & value;
  end

  rb_or_merge #(.DW(DW), .NSRC(NREG)) u_or (
    .src    (gated),
    .merged (rdata)
  );
endmodule

// File: rtl/rb_dual_bank.sv
module rb_dual_bank #(
  parameter int BASE_A = 16'h3456,
  parameter int BASE_B = 16'h5000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] bus_addr,
  input  logic        bus_wr,
  input  logic [15:0] bus_wdata,
  input  logic        stat_a,
  input  logic        stat_b,
  output logic [15:0] bus_rdata
);
  import rb_pkg::*;

  logic [NREG*DW-1:0] ro_a, ro_b;
  logic [2*DW-1:0]    bank_out;

  assign ro_a = {{DW{1'b0}}, stat_a, {(DW-1){1'b0}}};
  assign ro_b = {{DW{1'b0}}, stat_b, {(DW-1){1'b0}}};

  rb_bank #(.BASE(BASE_A)) u_bank_a (
    .clk (clk), .rst (rst), .addr (bus_addr), .wr (bus_wr),
    .wdata (bus_wdata), .ro_flat (ro_a), .rdata (bank_out[0 +: DW])
  );

  rb_bank #(.BASE(BASE_B)) u_bank_b (
    .clk (clk), .rst (rst), .addr (bus_addr), .wr (bus_wr),
    .wdata (bus_wdata), .ro_flat (ro_b), .rdata (bank_out[DW +: DW])
  );

  rb_or_merge #(.DW(DW), .NSRC(2)) u_top_or (
    .src    (bank_out),
    .merged (bus_rdata)
  );
endmodule

// File: rtl/rb_dual_bank_chk.sv
module rb_dual_bank_chk #(
  parameter int BASE_A = 16'h3456,
  parameter int BASE_B = 16'h5000
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] bus_addr,
  input logic        bus_wr,
  input logic [15:0] bus_wdata,
  input logic        stat_a,
  input logic        stat_b,
  input logic [15:0] bus_rdata
);
  localparam logic [15:0] A0 = 16'(BASE_A);
  localparam logic [15:0] A1 = 16'(BASE_A + 1);
  localparam logic [15:0] B0 = 16'(BASE_B);
  localparam logic [15:0] B1 = 16'(BASE_B + 1);

  logic mapped;
  assign mapped = (bus_addr == A0) || (bus_addr == A1) ||
                  (bus_addr == B0) || (bus_addr == B1);

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !mapped |-> bus_rdata == 16'h0000); // R6

  AST_DATA_HOLES_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A1 || bus_addr == B1) |-> (bus_rdata[4] == 1'b0 && bus_rdata[2] == 1'b0)); // R2

  AST_CTRL_A_STATUS: assert property (@(posedge clk) disable iff (rst)
    bus_addr == A0 |-> bus_rdata == {stat_a, 15'h0}); // R3

  AST_CTRL_B_STATUS: assert property (@(posedge clk) disable iff (rst)
    bus_addr == B0 |-> bus_rdata == {stat_b, 15'h0}); // R8

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A1 && $past(bus_addr) == A1 && $past(bus_wr) && !$past(rst))
      |-> bus_rdata == ($past(bus_wdata) & 16'hFFEB)); // R1

  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A1 && $past(bus_addr) == A1 && !$past(bus_wr) && !$past(rst))
      |-> $stable(bus_rdata)); // R5

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && (bus_addr == A1 || bus_addr == B1)) |-> bus_rdata == 16'h0000); // R7
endmodule

bind rb_dual_bank rb_dual_bank_chk #(.BASE_A(BASE_A), .BASE_B(BASE_B)) u_chk (
  .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_wr (bus_wr),
  .bus_wdata (bus_wdata), .stat_a (stat_a), .stat_b (stat_b),
  .bus_rdata (bus_rdata)
);

// File: tb/rb_dual_bank_bench.sv
`timescale 1ns/1ps
module rb_dual_bank_bench;
  localparam logic [15:0] A0 = 16'h3456, A1 = 16'h3457;
  localparam logic [15:0] B0 = 16'h5000, B1 = 16'h5001;
  localparam logic [15:0] DMASK = 16'hFFEB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        stat_a = 1'b0, stat_b = 1'b0;
  logic [15:0] bus_rdata;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] mdl_a = '0, mdl_b = '0;

  always #2.5 clk = ~clk;

  rb_dual_bank u_rb_dual_bank (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_wr (bus_wr),
    .bus_wdata (bus_wdata), .stat_a (stat_a), .stat_b (stat_b),
    .bus_rdata (bus_rdata)
  );

  function automatic logic [15:0] expect_rd(logic [15:0] a);
    case (a)
      A0: return {stat_a, 15'h0};
      A1: return mdl_a;
      B0: return {stat_b, 15'h0};
      B1: return mdl_b;
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_write(logic [15:0] a, logic [15:0] d);
    if (a == A1) mdl_a = d & DMASK;
    if (a == B1) mdl_b = d & DMASK;
  endtask

  task automatic check_at(logic [15:0] a, string req);
    logic [15:0] e;
    @(negedge clk);
    bus_addr = a;
    bus_wr = 1'b0;
    #1;
    e = expect_rd(a);
    checks++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, bus_rdata, e);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [15:0] d, logic strobe);
    @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_wr = strobe;
    @(negedge clk);
    bus_wr = 1'b0;
    if (strobe) model_write(a, d);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    check_at(A1, "R7");
    check_at(B1, "R7");
    check_at(A0, "R3");
    // all-ones write exposes the unused holes
    bus_write(A1, 16'hFFFF, 1'b1);
    check_at(A1, "R2");
    check_at(B1, "R8");
    bus_write(B1, 16'h5A5A, 1'b1);
    check_at(B1, "R1");
    check_at(A1, "R8");
    // control word is read-only
    bus_write(A0, 16'hFFFF, 1'b1);
    check_at(A0, "R4");
    check_at(A1, "R4");
    // status is visible combinationally
    stat_a = 1'b1;
    check_at(A0, "R3");
    stat_b = 1'b1;
    check_at(B0, "R9");
    stat_a = 1'b0;
    check_at(A0, "R3");
    // strobe low leaves storage alone
    bus_write(A1, 16'h0000, 1'b0);
    check_at(A1, "R5");
    // neighbours of each bank are unmapped
    check_at(16'h3455, "R6");
    check_at(16'h3458, "R6");
    check_at(16'h4FFF, "R6");
    check_at(16'h5002, "R6");
    check_at(16'h0000, "R6");
    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      int k;
      k = int'($urandom % 7);
      case (k)
        0: a = A0;
        1: a = A1;
        2: a = B0;
        3: a = B1;
        4: a = A1 + 16'd1;
        default: a = 16'($urandom);
      endcase
      stat_a = 1'($urandom);
      stat_b = 1'($urandom);
      bus_write(a, 16'($urandom), 1'($urandom));
      check_at(a, "R8");
    end
    // mid-run reset
    bus_write(A1, 16'h1234, 1'b1);
    bus_write(B1, 16'hFEDC, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    mdl_a = '0; mdl_b = '0;
    check_at(A1, "R7");
    check_at(B1, "R7");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule